// File: doc/BRIEF.md
# LED Demo Pattern Generator

This block animates an eight-bit LED port. A two-bit mode input picks one of three moving patterns, plus a blank setting: a two-LED "ball" that runs from the top of the port to the bottom and back, a binary up-counter, or a single lit LED that swings from end to end like a pendulum. The pattern moves one step each time an internal interval timer expires. The timer's period is a parameter, given in clock cycles.

The design registers the mode input. Changing the mode puts the newly chosen pattern back at its starting point and restarts the interval timer. The first step of the new pattern therefore always comes one full interval after the change. All pattern state is registered, so the LED outputs have no combinational path from the inputs.

Top module: `led_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after release until the first step, `leds` shows the bouncing-pair start pattern 8'hC0.
- R2: Mode codes are: 0 for the bouncing pair, 1 for the binary counter, 2 for the pendulum and 3 for blank. Bit 7 of `leds` is the most significant LED.
- R3: A pattern advances exactly once every `TICK_CYCLES` clock edges. The first step comes `TICK_CYCLES` edges after the edge that releases reset or samples a new mode, and the output holds steady between steps.
- R4: In bouncing-pair mode the sequence is C0, 60, 30, 18, 0C, 06, 03, 06, 0C, 18, 30, 60, C0, and so on. Neither end position repeats at a reversal, so the period is 12 steps.
- R5: In bouncing-pair mode exactly two adjacent LEDs are lit at all times.
- R6: In counter mode `leds` starts at 00 and increases by one per step, wrapping from FF to 00.
- R7: In pendulum mode exactly one LED is lit. It sweeps 80, 40, …, 01, 02, …, 80 without repeating an end position, so the period is 14 steps.
- R8: On the first clock edge that samples a mode value different from the previous one, `leds` takes the new mode's start pattern (C0, 00 or 80). The interval timer also restarts, even if the change falls mid-interval.
- R9: In blank mode all LEDs are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Pattern select: 0 pair, 1 counter, 2 pendulum, 3 blank |
| leds | output | 8 | LED drive bits, bit 7 most significant |

## Verification
A new mode takes effect at the first rising edge that samples it. The start pattern is visible right after that edge, and each later step appears exactly `TICK_CYCLES` edges after the one before. After reset release the first step likewise lands `TICK_CYCLES` edges later. The bench drives and samples on falling edges and counts edges from the change that it made. At `TICK_CYCLES-1` edges it confirms the previous pattern still holds, and at `TICK_CYCLES` it expects the next one. The expected values come from closed-form step-index formulas for each pattern. One scenario changes mode mid-interval to show that the timer restarts rather than carrying over its count.

// File: rtl/led_pat_pkg.sv
// Package: shared mode encoding for the LED pattern generator.
// Assumes a two-bit mode field; code 3 is the blank setting.
package led_pat_pkg;
    typedef enum logic [1:0] {
        PAT_PAIR  = 2'd0,
        PAT_COUNT = 2'd1,
        PAT_SWING = 2'd2,
        PAT_BLANK = 2'd3
    } pat_mode_e;
endpackage

// File: rtl/led_interval_timer.sv
// Interval prescaler: pulses `tick` once every TICK_CYCLES clock edges.
// Assumes TICK_CYCLES >= 2. `restart` clears the count, so the next
// tick falls a full interval after the restarting edge.
module led_interval_timer #(
    parameter int TICK_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(TICK_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Tick is the cycle the counter sits on its last value, unless restarting.
    assign tick = (cnt == LAST) && !restart;

    // Count cycles within the interval, wrapping on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/led_sweep.sv
// Sweep engine: a group of LIT_W adjacent lit LEDs that starts at the top
// of the port, moves one place down per step, and reverses at each end.
// End positions are not repeated. Assumes 1 <= LIT_W <= LED_W-2.
module led_sweep #(
    parameter int LED_W = 8,
    parameter int LIT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [LED_W-1:0] leds
);
    localparam int PW = $clog2(LED_W);
    localparam logic [PW-1:0]    TOP_POS  = PW'(LED_W - LIT_W);
    localparam logic [PW-1:0]    TURN_TOP = PW'(LED_W - LIT_W - 1);
    localparam logic [LED_W-1:0] LIT_MASK = LED_W'((1 << LIT_W) - 1);

    logic [PW-1:0] pos;   // index of the lowest lit LED
    logic          down;  // 1: moving toward bit 0

    // Track position and direction; turn around one step before each end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos  <= TOP_POS;
            down <= 1'b1;
        end else if (step) begin
            if (down) begin
                if (pos == PW'(1)) begin
                    pos  <= '0;
                    down <= 1'b0;
                end else begin
                    pos <= pos - 1'b1;
                end
            end else begin
                if (pos == TURN_TOP) begin
                    pos  <= TOP_POS;
                    down <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    // Place the lit group at the current position.
    always_comb begin
        leds = LIT_MASK << pos;
    end
endmodule

// File: rtl/led_counter.sv
// Binary step counter: counts up once per step, wrapping at all-ones.
// A restart returns it to zero.
module led_counter #(
    parameter int LED_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [LED_W-1:0] leds
);
    logic [LED_W-1:0] value;

    // Increment on each step; natural overflow gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            value <= '0;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end

    assign leds = value;
endmodule

// File: rtl/led_pattern_gen.sv
// LED pattern generator top: registers the mode select, restarts the
// timer and every pattern engine when the mode changes, and selects the
// engine output for the current mode. Assumes `mode` is synchronous to clk.
module led_pattern_gen #(
    parameter int LED_W       = 8,
    parameter int TICK_CYCLES = 5_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    output logic [LED_W-1:0] leds
);
    import led_pat_pkg::*;

    pat_mode_e        mode_q;
    logic             restart;
    logic             tick;
    logic [LED_W-1:0] pair_leds;
    logic [LED_W-1:0] count_leds;
    logic [LED_W-1:0] swing_leds;

    // A new mode value restarts everything at this edge.
    assign restart = (pat_mode_e'(mode) != mode_q);

    // Hold the mode seen at the last edge; reset selects the pair pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PAT_PAIR;
        end else begin
            mode_q <= pat_mode_e'(mode);
        end
    end

    led_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    led_sweep #(.LED_W(LED_W), .LIT_W(2)) i_pair (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(tick),
        .leds(pair_leds)
    );

    led_counter #(.LED_W(LED_W)) i_count (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(tick),
        .leds(count_leds)
    );

    led_sweep #(.LED_W(LED_W), .LIT_W(1)) i_swing (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(tick),
        .leds(swing_leds)
    );

    // Route the selected engine to the port; blank drives nothing.
    always_comb begin
        case (mode_q)
            PAT_PAIR:  leds = pair_leds;
            PAT_COUNT: leds = count_leds;
            PAT_SWING: leds = swing_leds;
            default:   leds = '0;
        endcase
    end
endmodule

// File: rtl/led_pattern_gen_chk.sv
// Checker for led_pattern_gen: observes the ports only and is bound in below.
// Assumes TICK_CYCLES >= 2, so no step falls on the edge after a restart.
module led_pattern_gen_chk #(
    parameter int LED_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [LED_W-1:0] leds
);
    localparam logic [LED_W-1:0] PAIR_TOP  = LED_W'(3) << (LED_W - 2);
    localparam logic [LED_W-1:0] SWING_TOP = LED_W'(1) << (LED_W - 1);

    // R5
    pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && $past(mode) == 2'd0)
        |-> ($countones(leds) == 2 && (leds & (leds >> 1)) != '0));

    // R7
    swing_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) == 2'd2) |-> $countones(leds) == 1);

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) == 2'd3) |-> leds == '0);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) == 2'd1 && $past(mode, 2) == 2'd1
         && leds != $past(leds))
        |-> leds == LED_W'($past(leds) + 1'b1));

    // R8
    pair_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && $past(mode) != 2'd0) |=> leds == PAIR_TOP);

    // R8
    count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) != 2'd1) |=> leds == '0);

    // R8
    swing_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) != 2'd2) |=> leds == SWING_TOP);
endmodule

bind led_pattern_gen led_pattern_gen_chk #(.LED_W(LED_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .leds(leds)
);

// File: tb/test_led_pattern_gen.sv
// Directed bench for led_pattern_gen: one task per scenario, each checking
// its own results on falling edges against closed-form step formulas.
module test_led_pattern_gen;
    localparam int N = 4;  // interval in clock cycles for this bench

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] leds;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    led_pattern_gen #(.LED_W(8), .TICK_CYCLES(N)) i_led_pattern_gen (
        .clk(clk), .rst_n(rst_n), .mode(mode), .leds(leds)
    );

    // Expected pattern for a mode after k steps from its start.
    function automatic logic [7:0] exp_pat(input logic [1:0] m, input int k);
        int r;
        int p;
        case (m)
            2'd0: begin
                r = k % 12;
                p = (r <= 6) ? 6 - r : r - 6;
                return 8'h03 << p;
            end
            2'd1: return k[7:0];
            2'd2: begin
                r = k % 14;
                p = (r <= 7) ? 7 - r : r - 7;
                return 8'h01 << p;
            end
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: leds=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Walk steps 1..n of mode m, also checking that nothing moves one edge early.
    task automatic step_through(input logic [1:0] m, input int n, input string req);
        for (int k = 1; k <= n; k++) begin
            repeat (N - 1) @(negedge clk);
            chk({req, " R3 hold"}, leds, exp_pat(m, k - 1));
            @(negedge clk);
            chk(req, leds, exp_pat(m, k));
        end
    endtask

    // Select a new mode; its start pattern is due after the next edge.
    task automatic enter_mode(input logic [1:0] m);
        mode = m;
        @(negedge clk);
        chk("R8 start", leds, exp_pat(m, 0));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        mode  = 2'd0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", leds, 8'hC0);
        rst_n = 1'b1;
        chk("R1 released", leds, 8'hC0);
    endtask

    task automatic t_pair;
        step_through(2'd0, 26, "R4 R5 pair");
    endtask

    task automatic t_count_wrap;
        enter_mode(2'd1);
        step_through(2'd1, 258, "R6 count");
    endtask

    task automatic t_swing;
        enter_mode(2'd2);
        step_through(2'd2, 30, "R7 swing");
    endtask

    // Change mode two edges into an interval: the timer must start afresh.
    task automatic t_mid_restart;
        enter_mode(2'd1);
        step_through(2'd1, 1, "R6 count");
        repeat (2) @(negedge clk);
        enter_mode(2'd2);
        step_through(2'd2, 2, "R8 R3 restart");
        enter_mode(2'd0);
        step_through(2'd0, 2, "R8 R2 pair again");
    endtask

    task automatic t_blank;
        enter_mode(2'd3);
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            chk("R9 blank", leds, 8'h00);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: leds=%h expected progress", leds);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pair();
        t_count_wrap();
        t_swing();
        t_mid_restart();
        t_blank();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule